// File: doc/BRIEF.md
# Signed-Count Logical Shifter

This unit is a 32-bit logical shifter for a processor execution stage. One signed count sets both the direction and the distance of the shift. The operand arrives with a 16-bit count half-word. Only the low six bits of that half-word are read, as a two's-complement number from -32 to +31. A count at or above zero shifts toward the most significant bit. A count below zero shifts toward the least significant bit by its magnitude. Every vacated position is filled with zero, so the operand's top bit is never copied into the result.

Next to the 32-bit result the unit gives a zero flag and a negative flag. By default the result and both flags are held in an output register. They appear one clock after an input marked valid, and `out_valid` qualifies them. Setting a parameter removes the register, and the outputs then follow the inputs combinationally.

Top module: `lsh_unit`

## Requirements
- R1: The count is bits [5:0] of `count_hw`, read as a signed value. Bits [15:6] have no effect on the result. For example, 0x7F01 shifts left by 1 and 0xCF12 shifts left by 18.
- R2: A count from +1 to +31 shifts `operand` left by that many places and fills the low bits with zero. For example, 0x01210001 shifted by +1 gives 0x02420002, and shifting by +16 moves the low half-word into the high half.
- R3: A count from -1 to -31 shifts `operand` right by its magnitude and fills the high bits with zero, whatever bit 31 of the operand holds. For example, 0xC6789A7C shifted by -16 gives 0x0000C678.
- R4: Bits moved past either end of the word are lost. For example, 0x12345678 shifted by +15 gives 0x2B3C0000, and 0x0000024E shifted by -15 gives 0.
- R5: A count field of 0 (binary 000000) returns `operand` unchanged.
- R6: `zero_flag` is 1 exactly when the 32-bit result is zero.
- R7: `neg_flag` equals bit 31 of the result.
- R8: With the output register in place, an input with `in_valid` high gives `out_valid` high one clock later, together with its result and flags. A cycle with `in_valid` low gives `out_valid` low one clock later.
- R9: A synchronous, active-high `rst` clears `out_valid` at the next clock edge, even when `in_valid` is high in the same cycle.
- R10: A count field of -32 (binary 100000) gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset; clears out_valid |
| in_valid | input | 1 | Marks operand and count_hw as a request |
| operand | input | 32 | Word to be shifted |
| count_hw | input | 16 | Half-word whose low six bits hold the signed count |
| result | output | 32 | Shifted word |
| zero_flag | output | 1 | 1 when result is all zeros |
| neg_flag | output | 1 | Copy of result bit 31 |
| out_valid | output | 1 | Qualifies result and flags |

## Verification
On every cycle the assertions check the following:
- Each flag agrees with the result it is presented with.
- `out_valid` follows `in_valid` by exactly one clock.
- A zero count field returns the operand it was given one cycle earlier.
- A -32 count field clears the word.

Only the bench's vectors can show the following:
- The actual shifted values in both directions.
- That the ignored upper count bits change nothing.
- That a set bit 31 does not leak into a right shift.
- That a reset arriving with a valid input drops that input.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

    // Direction chosen by the sign of the count field.
    typedef enum logic {
        LSH_DIR_LEFT  = 1'b0,
        LSH_DIR_RIGHT = 1'b1
    } lsh_dir_e;

endpackage

// File: rtl/lsh_count_decode.sv
// Turns the signed count field into a direction, a magnitude and a
// flag that says the magnitude empties the whole word.
module lsh_count_decode #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [CNT_W-1:0]   field_i,
    output lsh_pkg::lsh_dir_e  dir_o,
    output logic [CNT_W-1:0]   mag_o,
    output logic               wipe_o
);
    localparam logic [31:0] WIDTH_LIM = 32'(DATA_W);

    logic [CNT_W-1:0] mag_d;

    always_comb begin
        if (field_i[CNT_W-1]) begin
            dir_o = lsh_pkg::LSH_DIR_RIGHT;
            mag_d = ~field_i + CNT_W'(1);
        end else begin
            dir_o = lsh_pkg::LSH_DIR_LEFT;
            mag_d = field_i;
        end
        mag_o  = mag_d;
        wipe_o = ({{(32-CNT_W){1'b0}}, mag_d} >= WIDTH_LIM);
    end

endmodule

// File: rtl/lsh_bit_reverse.sv
// Mirrors a word end for end so a left network can serve right shifts.
module lsh_bit_reverse #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign q_o[b] = d_i[DATA_W-1-b];
    end
endmodule

// File: rtl/lsh_left_net.sv
// Log-depth left shifter: stage k moves the word by 2**k places when
// bit k of the amount is set, inserting zeros at the bottom.
module lsh_left_net #(
    parameter int DATA_W = 32,
    parameter int STG    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] d_i,
    input  logic [STG-1:0]    amt_i,
    output logic [DATA_W-1:0] q_o
);
    logic [DATA_W-1:0] lvl [0:STG];

    assign lvl[0] = d_i;

    for (genvar g = 0; g < STG; g++) begin : g_stage
        localparam int SH = 1 << g;
        assign lvl[g+1] = amt_i[g] ? {lvl[g][DATA_W-1-SH:0], {SH{1'b0}}}
                                   : lvl[g];
    end

    assign q_o = lvl[STG];
endmodule

// File: rtl/lsh_unit.sv
module lsh_unit #(
    parameter int DATA_W  = 32,
    parameter int HALF_W  = 16,
    parameter int CNT_W   = 6,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] operand,
    input  logic [HALF_W-1:0] count_hw,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag,
    output logic              neg_flag,
    output logic              out_valid
);
    localparam int STG = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] res;
        logic              zf;
        logic              nf;
    } lsh_state_t;

    // Upper half-word bits are deliberately not used (R1).
    logic unused_count_hi;
    assign unused_count_hi = ^count_hw[HALF_W-1:CNT_W];

    lsh_pkg::lsh_dir_e dir;
    logic [CNT_W-1:0]  mag;
    logic              wipe;

    lsh_count_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
        .field_i (count_hw[CNT_W-1:0]),
        .dir_o   (dir),
        .mag_o   (mag),
        .wipe_o  (wipe)
    );

    logic [DATA_W-1:0] op_rev, net_in, net_out, out_rev, shifted;

    lsh_bit_reverse #(.DATA_W(DATA_W)) u_rev_in (
        .d_i (operand),
        .q_o (op_rev)
    );

    assign net_in = (dir == lsh_pkg::LSH_DIR_RIGHT) ? op_rev : operand;

    lsh_left_net #(.DATA_W(DATA_W), .STG(STG)) u_net (
        .d_i   (net_in),
        .amt_i (mag[STG-1:0]),
        .q_o   (net_out)
    );

    lsh_bit_reverse #(.DATA_W(DATA_W)) u_rev_out (
        .d_i (net_out),
        .q_o (out_rev)
    );

    always_comb begin
        if (wipe)
            shifted = '0;
        else if (dir == lsh_pkg::LSH_DIR_RIGHT)
            shifted = out_rev;
        else
            shifted = net_out;
    end

    if (REG_OUT) begin : g_reg
        lsh_state_t state_d, state_q;

        always_comb begin
            state_d       = state_q;
            state_d.valid = in_valid;
            if (in_valid) begin
                state_d.res = shifted;
                state_d.zf  = (shifted == '0);
                state_d.nf  = shifted[DATA_W-1];
            end
        end

        always_ff @(posedge clk) begin
            state_q <= state_d;
            if (rst)
                state_q.valid <= 1'b0;
        end

        assign result    = state_q.res;
        assign zero_flag = state_q.zf;
        assign neg_flag  = state_q.nf;
        assign out_valid = state_q.valid;

        p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        p_idle_follow_r8: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        p_zero_count_pass_r5: assert property (@(posedge clk) disable iff (rst)
            (in_valid && count_hw[CNT_W-1:0] == '0) |=> (result == $past(operand)));
        p_min_count_clear_r10: assert property (@(posedge clk) disable iff (rst)
            (in_valid && count_hw[CNT_W-1:0] == CNT_MIN) |=> (result == '0));
    end else begin : g_comb
        assign result    = shifted;
        assign zero_flag = (shifted == '0);
        assign neg_flag  = shifted[DATA_W-1];
        assign out_valid = in_valid;
    end

    p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (zero_flag == (result == '0)));
    p_neg_flag_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (neg_flag == result[DATA_W-1]));

endmodule

// File: tb/sim_lsh_unit.sv
`timescale 1ns/1ps
module sim_lsh_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [15:0] count_hw = '0;
    logic [31:0] result;
    logic        zero_flag, neg_flag, out_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lsh_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .count_hw(count_hw), .result(result), .zero_flag(zero_flag),
        .neg_flag(neg_flag), .out_valid(out_valid)
    );

    typedef struct packed {
        logic [31:0] op;
        logic [15:0] cnt;
        logic [31:0] exp;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{32'h01210001, 16'h0001, 32'h02420002, "R2"},   // left by 1
        '{32'h3451789A, 16'hCF12, 32'hE2680000, "R1"},   // field 0x12 = +18
        '{32'h12345678, 16'h7F01, 32'h2468ACF0, "R1"},   // upper bits ignored
        '{32'h567C9ABC, 16'h0010, 32'h9ABC0000, "R2"},   // +16 half move
        '{32'hC6789A7C, 16'hFFF0, 32'h0000C678, "R3"},   // -16, no sign fill
        '{32'h82365678, 16'hFFF8, 32'h00823656, "R3"},   // -8
        '{32'h80000001, 16'h003F, 32'h40000000, "R3"},   // -1
        '{32'h12345678, 16'h000F, 32'h2B3C0000, "R4"},   // +15 loses top bits
        '{32'h0000024E, 16'hFFF1, 32'h00000000, "R4"},   // -15 empties
        '{32'hA5A5A5A5, 16'hFFC0, 32'hA5A5A5A5, "R5"},   // field zero
        '{32'hFFFFFFFF, 16'h0020, 32'h00000000, "R10"},  // field -32
        '{32'h00000001, 16'h001F, 32'h80000000, "R2"}    // +31 sets bit 31
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", {31'b0, out_valid}, 32'd0);

        // R8: idle input after reset gives no valid output
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8", {31'b0, out_valid}, 32'd0);

        // Table walk, back to back
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            operand  = VECS[i].op;
            count_hw = VECS[i].cnt;
            @(negedge clk);
            chk("R8", {31'b0, out_valid}, 32'd1);
            chk($sformatf("%s", VECS[i].tag), result, VECS[i].exp);
            chk("R6", {31'b0, zero_flag}, {31'b0, VECS[i].exp == 32'd0});
            chk("R7", {31'b0, neg_flag}, {31'b0, VECS[i].exp[31]});
        end

        // R8: valid drops one cycle after in_valid drops
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8", {31'b0, out_valid}, 32'd0);

        // R9: reset beats a simultaneous valid input
        in_valid = 1'b1;
        operand  = 32'h12345678;
        count_hw = 16'h0004;
        rst      = 1'b1;
        @(negedge clk);
        chk("R9", {31'b0, out_valid}, 32'd0);

        // After release, the same request is served
        rst = 1'b0;
        @(negedge clk);
        chk("R8", {31'b0, out_valid}, 32'd1);
        chk("R2", result, 32'h23456780);
        in_valid = 1'b0;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule